// File: doc/BRIEF.md
# Register-Format Integer ALU with Function Decode

This block executes the register-to-register integer operations of a 32-bit processor pipeline. It takes a 6-bit function code, a 5-bit immediate shift distance and two source operands, `rs` and `rt`. From these it produces a result word, a signed-overflow trap flag, an illegal-function flag and a destination write enable. The function code selects the operation directly, using fixed architectural values. The decoded operation is carried as an enumerated class. The class is never an encoding of its own.

The datapath is combinational and ends in one output register. An operation presented with `in_valid` high in one cycle appears on the outputs after the next rising clock edge. `out_valid` marks it. The write enable tells the register-file stage whether to commit the result. It is withheld when the operation traps on signed overflow, and when the function code is not one the block implements.

Top module: `alu_rtype`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it, `out_valid`, `wr_en`, `ovf_trap`, `illegal` and `result` are all 0.
- R2: An operation accepted with `in_valid`=1 at a rising edge is presented with `out_valid`=1 after that edge. When `out_valid` is 0, the outputs `wr_en`, `ovf_trap` and `illegal` are 0.
- R3: Function 0x20 adds `rs`+`rt` and function 0x22 subtracts `rs`-`rt`. Either one sets `ovf_trap`=1 when the signed result overflows. The result then carries the wrapped 32-bit value and `wr_en` is 0.
- R4: Functions 0x21 and 0x23 compute the same sum and difference as 0x20 and 0x22, but they never set `ovf_trap`, even when the signed result wraps.
- R5: The bitwise operations use these function codes: AND is 0x24, OR is 0x25, XOR is 0x26 and NOR is 0x27.
- R6: Function 0x2A returns 1 when `rs` is less than `rt` as two's-complement numbers. Function 0x2B returns 1 when `rs` is less than `rt` as unsigned numbers. Both return 0 otherwise.
- R7: The immediate shifts shift `rt` by `shamt` and ignore `rs`. Function 0x00 is a logical left shift, 0x02 is a logical right shift and 0x03 is an arithmetic right shift.
- R8: The variable shifts shift `rt` by `rs[4:0]` and ignore `shamt` and `rs[31:5]`. Function 0x04 shifts left, 0x06 shifts right logically and 0x07 shifts right arithmetically.
- R9: Any other function code sets `illegal`=1, `wr_en`=0, `ovf_trap`=0 and `result`=0.
- R10: A valid, legal operation that does not trap presents `wr_en`=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operation present this cycle |
| func | input | 6 | Function code |
| shamt | input | 5 | Immediate shift distance |
| rs_val | input | 32 | First source operand |
| rt_val | input | 32 | Second source operand, and the shifted value |
| out_valid | output | 1 | Registered result is valid |
| result | output | 32 | Registered result word |
| wr_en | output | 1 | Commit result to destination |
| ovf_trap | output | 1 | Signed overflow on a trapping add or subtract |
| illegal | output | 1 | Function code not implemented |

## Verification
Signed-overflow detection and write suppression meet in the same output cycle. The bench provokes this by driving the trapping add and subtract with the boundary operands 0x7FFFFFFF, 0x80000000 and 0xFFFFFFFF. It then expects `ovf_trap` high, `wr_en` low and the wrapped sum on `result`, all in that one cycle. The non-trapping twins receive the same operand pairs, and the bench requires `wr_en` high with the trap flag low. Every legal code is also run over all pairs of the corner operands and over random operands, and is compared against a behavioural model. Random function codes, some of them illegal, are mixed in to confirm that the illegal flag and the trap flag never rise together.

// File: rtl/alu_pkg.sv
package alu_pkg;

    localparam int DATA_W  = 32;
    localparam int FUNC_W  = 6;
    localparam int SHAMT_W = $clog2(DATA_W);

    localparam logic [FUNC_W-1:0] FN_SLL  = 6'h00;
    localparam logic [FUNC_W-1:0] FN_SRL  = 6'h02;
    localparam logic [FUNC_W-1:0] FN_SRA  = 6'h03;
    localparam logic [FUNC_W-1:0] FN_SLLV = 6'h04;
    localparam logic [FUNC_W-1:0] FN_SRLV = 6'h06;
    localparam logic [FUNC_W-1:0] FN_SRAV = 6'h07;
    localparam logic [FUNC_W-1:0] FN_ADD  = 6'h20;
    localparam logic [FUNC_W-1:0] FN_ADDU = 6'h21;
    localparam logic [FUNC_W-1:0] FN_SUB  = 6'h22;
    localparam logic [FUNC_W-1:0] FN_SUBU = 6'h23;
    localparam logic [FUNC_W-1:0] FN_AND  = 6'h24;
    localparam logic [FUNC_W-1:0] FN_OR   = 6'h25;
    localparam logic [FUNC_W-1:0] FN_XOR  = 6'h26;
    localparam logic [FUNC_W-1:0] FN_NOR  = 6'h27;
    localparam logic [FUNC_W-1:0] FN_SLT  = 6'h2A;
    localparam logic [FUNC_W-1:0] FN_SLTU = 6'h2B;

    typedef enum logic [3:0] {
        OP_ARITH,
        OP_AND,
        OP_OR,
        OP_XOR,
        OP_NOR,
        OP_LESS,
        OP_SHIFT,
        OP_NONE
    } alu_op_e;

    typedef enum logic [1:0] {
        SH_LEFT,
        SH_RIGHT_LOG,
        SH_RIGHT_ARI
    } shift_kind_e;

    typedef struct packed {
        alu_op_e     op;
        logic        subtract;
        logic        trapping;
        logic        unsigned_cmp;
        shift_kind_e shift_kind;
        logic        shift_by_reg;
        logic        bad_code;
    } alu_ctrl_t;

endpackage

// File: rtl/alu_decode.sv
module alu_decode
    import alu_pkg::*;
(
    input  logic [FUNC_W-1:0] func,
    output alu_ctrl_t         ctrl
);

    always_comb begin
        ctrl              = '0;
        ctrl.op           = OP_NONE;
        ctrl.shift_kind   = SH_LEFT;
        unique case (func)
            FN_ADD:  begin ctrl.op = OP_ARITH; ctrl.trapping = 1'b1; end
            FN_ADDU: begin ctrl.op = OP_ARITH; end
            FN_SUB:  begin ctrl.op = OP_ARITH; ctrl.subtract = 1'b1; ctrl.trapping = 1'b1; end
            FN_SUBU: begin ctrl.op = OP_ARITH; ctrl.subtract = 1'b1; end
            FN_AND:  ctrl.op = OP_AND;
            FN_OR:   ctrl.op = OP_OR;
            FN_XOR:  ctrl.op = OP_XOR;
            FN_NOR:  ctrl.op = OP_NOR;
            FN_SLT:  begin ctrl.op = OP_LESS; ctrl.subtract = 1'b1; end
            FN_SLTU: begin ctrl.op = OP_LESS; ctrl.subtract = 1'b1; ctrl.unsigned_cmp = 1'b1; end
            FN_SLL:  begin ctrl.op = OP_SHIFT; ctrl.shift_kind = SH_LEFT; end
            FN_SRL:  begin ctrl.op = OP_SHIFT; ctrl.shift_kind = SH_RIGHT_LOG; end
            FN_SRA:  begin ctrl.op = OP_SHIFT; ctrl.shift_kind = SH_RIGHT_ARI; end
            FN_SLLV: begin ctrl.op = OP_SHIFT; ctrl.shift_kind = SH_LEFT; ctrl.shift_by_reg = 1'b1; end
            FN_SRLV: begin ctrl.op = OP_SHIFT; ctrl.shift_kind = SH_RIGHT_LOG; ctrl.shift_by_reg = 1'b1; end
            FN_SRAV: begin ctrl.op = OP_SHIFT; ctrl.shift_kind = SH_RIGHT_ARI; ctrl.shift_by_reg = 1'b1; end
            default: begin ctrl.op = OP_NONE; ctrl.bad_code = 1'b1; end
        endcase
    end

    // R9: only the catch-all class may carry the bad-code mark
    always_comb begin
        a_r9_bad_code_class : assert (!ctrl.bad_code || ctrl.op == OP_NONE);
    end

endmodule

// File: rtl/alu_addsub.sv
module alu_addsub
    import alu_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         subtract,
    output logic [W-1:0] sum,
    output logic         signed_ovf,
    output logic         less_signed,
    output logic         less_unsigned
);

    logic [W-1:0] b_eff;
    logic [W:0]   wide;

    always_comb begin
        b_eff         = subtract ? ~b : b;
        wide          = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, subtract};
        sum           = wide[W-1:0];
        signed_ovf    = (a[W-1] == b_eff[W-1]) && (sum[W-1] != a[W-1]);
        less_signed   = sum[W-1] ^ signed_ovf;
        less_unsigned = ~wide[W];
    end

endmodule

// File: rtl/alu_shifter.sv
module alu_shifter
    import alu_pkg::*;
#(
    parameter int W  = DATA_W,
    parameter int SW = $clog2(W)
) (
    input  logic [W-1:0]  value,
    input  logic [SW-1:0] amount,
    input  shift_kind_e   kind,
    output logic [W-1:0]  shifted
);

    logic [W-1:0] stage [SW+1];
    logic         fill;
    logic         go_left;

    assign fill     = (kind == SH_RIGHT_ARI) ? value[W-1] : 1'b0;
    assign go_left  = (kind == SH_LEFT);
    assign stage[0] = value;

    for (genvar i = 0; i < SW; i++) begin : g_stage
        localparam int STEP = 1 << i;
        logic [W-1:0] left_v;
        logic [W-1:0] right_v;
        assign left_v   = {stage[i][W-1-STEP:0], {STEP{1'b0}}};
        assign right_v  = {{STEP{fill}}, stage[i][W-1:STEP]};
        assign stage[i+1] = !amount[i] ? stage[i] : (go_left ? left_v : right_v);
    end

    assign shifted = stage[SW];

endmodule

// File: rtl/alu_rtype.sv
module alu_rtype
    import alu_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [FUNC_W-1:0]   func,
    input  logic [SHAMT_W-1:0]  shamt,
    input  logic [DATA_W-1:0]   rs_val,
    input  logic [DATA_W-1:0]   rt_val,
    output logic                out_valid,
    output logic [DATA_W-1:0]   result,
    output logic                wr_en,
    output logic                ovf_trap,
    output logic                illegal
);

    alu_ctrl_t           ctrl;
    logic [DATA_W-1:0]   as_sum;
    logic                as_ovf;
    logic                as_lt_s;
    logic                as_lt_u;
    logic [SHAMT_W-1:0]  sh_amount;
    logic [DATA_W-1:0]   sh_out;
    logic [DATA_W-1:0]   next_result;
    logic                next_trap;

    alu_decode i_decode (
        .func (func),
        .ctrl (ctrl)
    );

    alu_addsub #(.W(DATA_W)) i_addsub (
        .a             (rs_val),
        .b             (rt_val),
        .subtract      (ctrl.subtract),
        .sum           (as_sum),
        .signed_ovf    (as_ovf),
        .less_signed   (as_lt_s),
        .less_unsigned (as_lt_u)
    );

    assign sh_amount = ctrl.shift_by_reg ? rs_val[SHAMT_W-1:0] : shamt;

    alu_shifter #(.W(DATA_W), .SW(SHAMT_W)) i_shifter (
        .value   (rt_val),
        .amount  (sh_amount),
        .kind    (ctrl.shift_kind),
        .shifted (sh_out)
    );

    always_comb begin
        next_trap = 1'b0;
        unique case (ctrl.op)
            OP_ARITH: begin
                next_result = as_sum;
                next_trap   = ctrl.trapping && as_ovf;
            end
            OP_AND:   next_result = rs_val & rt_val;
            OP_OR:    next_result = rs_val | rt_val;
            OP_XOR:   next_result = rs_val ^ rt_val;
            OP_NOR:   next_result = ~(rs_val | rt_val);
            OP_LESS:  next_result = {{(DATA_W-1){1'b0}},
                                     ctrl.unsigned_cmp ? as_lt_u : as_lt_s};
            OP_SHIFT: next_result = sh_out;
            OP_NONE:  next_result = '0;
            default:  next_result = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            result    <= '0;
            wr_en     <= 1'b0;
            ovf_trap  <= 1'b0;
            illegal   <= 1'b0;
        end else begin
            out_valid <= in_valid;
            wr_en     <= in_valid && !next_trap && !ctrl.bad_code;
            ovf_trap  <= in_valid && next_trap;
            illegal   <= in_valid && ctrl.bad_code;
            if (in_valid) begin
                result <= next_result;
            end
        end
    end

    // R2: an accepted operation shows up one edge later
    a_r2_valid_follows : assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R2: no flag without a valid result
    a_r2_idle_quiet : assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (!wr_en && !ovf_trap && !illegal));

    // R3: a trap never commits
    a_r3_trap_blocks_write : assert property (@(posedge clk) disable iff (!rst_n)
        ovf_trap |-> !wr_en);

    // R3: adding operands of opposite sign cannot overflow
    a_r3_mixed_sign_add : assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && func == FN_ADD && rs_val[DATA_W-1] != rt_val[DATA_W-1]) |=> !ovf_trap);

    // R4: non-trapping twins never raise the trap
    a_r4_no_overflow : assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (func == FN_ADDU || func == FN_SUBU)) |=> !ovf_trap);

    // R9: illegal code blocks the write and never traps
    a_r9_illegal_quiet : assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (!wr_en && !ovf_trap && result == '0));

    // R10: a valid result is either committed or flagged, exactly one way
    a_r10_one_outcome : assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $onehot({wr_en, ovf_trap, illegal}));

endmodule

// File: tb/test_alu_rtype.sv
`timescale 1ns/1ps
module test_alu_rtype;

    localparam real CLK_NS = 20.0;
    localparam int  NV     = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [5:0]  func = '0;
    logic [4:0]  shamt = '0;
    logic [31:0] rs_val = '0;
    logic [31:0] rt_val = '0;
    logic        out_valid;
    logic [31:0] result;
    logic        wr_en;
    logic        ovf_trap;
    logic        illegal;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #(CLK_NS/2) clk = ~clk;

    alu_rtype i_alu_rtype (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .func      (func),
        .shamt     (shamt),
        .rs_val    (rs_val),
        .rt_val    (rt_val),
        .out_valid (out_valid),
        .result    (result),
        .wr_en     (wr_en),
        .ovf_trap  (ovf_trap),
        .illegal   (illegal)
    );

    // func, shamt, rs, rt, expected result, expected {wr_en, ovf_trap, illegal}
    localparam logic [109:0] VEC [NV] = '{
        {6'h20, 5'd0,  32'h7FFFFFFF, 32'h00000001, 32'h80000000, 3'b010}, // R3
        {6'h21, 5'd0,  32'h7FFFFFFF, 32'h00000001, 32'h80000000, 3'b100}, // R4
        {6'h22, 5'd0,  32'h80000000, 32'h00000001, 32'h7FFFFFFF, 3'b010}, // R3
        {6'h23, 5'd0,  32'h80000000, 32'h00000001, 32'h7FFFFFFF, 3'b100}, // R4
        {6'h20, 5'd0,  32'hFFFFFFFF, 32'h00000001, 32'h00000000, 3'b100}, // R3
        {6'h24, 5'd0,  32'hF0F0F0F0, 32'hFF00FF00, 32'hF000F000, 3'b100}, // R5
        {6'h25, 5'd0,  32'hF0F0F0F0, 32'h0F0F0000, 32'hFFFFF0F0, 3'b100}, // R5
        {6'h26, 5'd0,  32'hFFFFFFFF, 32'h0F0F0F0F, 32'hF0F0F0F0, 3'b100}, // R5
        {6'h27, 5'd0,  32'h00000000, 32'h00000000, 32'hFFFFFFFF, 3'b100}, // R5
        {6'h2A, 5'd0,  32'h80000000, 32'h00000001, 32'h00000001, 3'b100}, // R6
        {6'h2B, 5'd0,  32'h80000000, 32'h00000001, 32'h00000000, 3'b100}, // R6
        {6'h00, 5'd4,  32'hFFFFFFFF, 32'h0000000F, 32'h000000F0, 3'b100}, // R7
        {6'h03, 5'd4,  32'h00000000, 32'h80000000, 32'hF8000000, 3'b100}, // R7
        {6'h02, 5'd31, 32'h12345678, 32'h80000000, 32'h00000001, 3'b100}, // R7
        {6'h07, 5'd0,  32'hFFFFFFE4, 32'h80000000, 32'hF8000000, 3'b100}, // R8
        {6'h06, 5'd9,  32'h00000020, 32'h12345678, 32'h12345678, 3'b100}, // R8
        {6'h04, 5'd0,  32'h0000001F, 32'h00000001, 32'h80000000, 3'b100}, // R8
        {6'h01, 5'd0,  32'h11111111, 32'h22222222, 32'h00000000, 3'b001}, // R9
        {6'h22, 5'd0,  32'h7FFFFFFF, 32'hFFFFFFFF, 32'h80000000, 3'b010}, // R3
        {6'h2A, 5'd0,  32'hFFFFFFFF, 32'h00000000, 32'h00000001, 3'b100}  // R6
    };

    localparam logic [31:0] CORNER [5] = '{
        32'h00000000, 32'h00000001, 32'h7FFFFFFF, 32'h80000000, 32'hFFFFFFFF
    };

    localparam logic [5:0] LEGAL [16] = '{
        6'h00, 6'h02, 6'h03, 6'h04, 6'h06, 6'h07, 6'h20, 6'h21,
        6'h22, 6'h23, 6'h24, 6'h25, 6'h26, 6'h27, 6'h2A, 6'h2B
    };

    function automatic string tag_of(input logic [5:0] f);
        case (f)
            6'h20, 6'h22:                return "R3";
            6'h21, 6'h23:                return "R4";
            6'h24, 6'h25, 6'h26, 6'h27:  return "R5";
            6'h2A, 6'h2B:                return "R6";
            6'h00, 6'h02, 6'h03:         return "R7";
            6'h04, 6'h06, 6'h07:         return "R8";
            default:                     return "R9";
        endcase
    endfunction

    task automatic ref_alu(input logic [5:0] f, input logic [4:0] sa,
                           input logic [31:0] a, input logic [31:0] b,
                           output logic [31:0] r, output logic [2:0] fl);
        logic t;
        logic ill;
        t = 1'b0;
        ill = 1'b0;
        case (f)
            6'h20: begin r = a + b; t = (a[31] == b[31]) && (r[31] != a[31]); end
            6'h21: r = a + b;
            6'h22: begin r = a - b; t = (a[31] != b[31]) && (r[31] != a[31]); end
            6'h23: r = a - b;
            6'h24: r = a & b;
            6'h25: r = a | b;
            6'h26: r = a ^ b;
            6'h27: r = ~(a | b);
            6'h2A: r = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
            6'h2B: r = (a < b) ? 32'd1 : 32'd0;
            6'h00: r = b << sa;
            6'h02: r = b >> sa;
            6'h03: r = $unsigned($signed(b) >>> sa);
            6'h04: r = b << a[4:0];
            6'h06: r = b >> a[4:0];
            6'h07: r = $unsigned($signed(b) >>> a[4:0]);
            default: begin r = '0; ill = 1'b1; end
        endcase
        fl = {!t && !ill, t, ill};
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // drive at a falling edge, capture at the rising edge, sample at the next falling edge
    task automatic run_op(input logic [5:0] f, input logic [4:0] sa,
                          input logic [31:0] a, input logic [31:0] b,
                          input logic [31:0] er, input logic [2:0] ef);
        @(negedge clk);
        in_valid = 1'b1;
        func = f;
        shamt = sa;
        rs_val = a;
        rt_val = b;
        @(negedge clk);
        in_valid = 1'b0;
        check("R2 out_valid", {31'd0, out_valid}, 32'd1);
        check(tag_of(f), result, er);
        check("R10 wr_en", {31'd0, wr_en}, {31'd0, ef[2]});
        check(tag_of(f), {31'd0, ovf_trap}, {31'd0, ef[1]});
        check(tag_of(f), {31'd0, illegal}, {31'd0, ef[0]});
    endtask

    task automatic run_ref(input logic [5:0] f, input logic [4:0] sa,
                           input logic [31:0] a, input logic [31:0] b);
        logic [31:0] er;
        logic [2:0]  ef;
        ref_alu(f, sa, a, b, er, ef);
        run_op(f, sa, a, b, er, ef);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        #(CLK_NS * 150000);
        bad++;
        total++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1 out_valid", {31'd0, out_valid}, 32'd0);
        check("R1 result", result, 32'd0);
        check("R1 flags", {29'd0, wr_en, ovf_trap, illegal}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 first cycle", {28'd0, out_valid, wr_en, ovf_trap, illegal}, 32'd0);

        // table walk
        for (int i = 0; i < NV; i++) begin
            run_op(VEC[i][109:104], VEC[i][103:99], VEC[i][98:67],
                   VEC[i][66:35], VEC[i][34:3], VEC[i][2:0]);
        end

        // R2: idle cycle drops every flag
        @(negedge clk);
        check("R2 idle", {28'd0, out_valid, wr_en, ovf_trap, illegal}, 32'd0);

        // R3 R4 and all codes over every corner pair
        for (int f = 0; f < 16; f++) begin
            for (int x = 0; x < 5; x++) begin
                for (int y = 0; y < 5; y++) begin
                    run_ref(LEGAL[f], 5'(x * 7 + y), CORNER[x], CORNER[y]);
                end
            end
        end

        // random codes, legal and illegal (R9), random operands
        for (int k = 0; k < 400; k++) begin
            run_ref(6'($urandom), 5'($urandom), $urandom, $urandom);
        end

        // R8: upper rs bits ignored, shamt ignored
        run_op(6'h06, 5'd31, 32'hFFFFFFE0, 32'hDEADBEEF, 32'hDEADBEEF, 3'b100);

        // R1: reset in the middle of a run clears the outputs
        run_op(6'h20, 5'd0, 32'h7FFFFFFF, 32'h7FFFFFFF, 32'hFFFFFFFE, 3'b010);
        rst_n = 1'b0;
        #1;
        check("R1 mid reset", {27'd0, out_valid, wr_en, ovf_trap, illegal, |result}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after reset", {28'd0, out_valid, wr_en, ovf_trap, illegal}, 32'd0);

        finish_run();
    end

endmodule